// File: doc/BRIEF.md
# ADC Conversion Sequencer with Result Buffer

This block is the digital side of an analog-to-digital converter. Once started, it loops through a sample phase followed by a conversion phase. Both phases are timed in units of a conversion clock period. That period is a chosen number of source clock ticks, and the source is either the system clock or an external slow strobe. In each conversion the block presents a channel number to the analog side and captures the value on the data input at the end. With scanning off, the channel is a fixed one. With scanning on, the block steps through a mask of enabled channels. Each captured value goes into a sixteen-entry result memory.

A four-bit count field groups conversions into blocks of count+1. At the end of each block three things happen on the same clock edge: an optional interrupt pulse, a restart of the channel scan, and a return of the memory write position to entry 0. A done flag reports that a conversion has finished. It drops only when the next conversion begins, or when software writes it to zero, and it stays high through the sample phase in between. Software programs the block through a small register write port and reads results through a one-cycle read port.

Top module: `adcseq_top`

## Requirements
- R1: After reset, conv_busy, done and irq are 0 and conv_ch is 0.
- R2: One conversion-clock period is (M+1) source ticks, where M is bits [5:0] of register address 1. Bit 15 of that register selects the source: 0 means every clk cycle and 1 means each cycle where rc_tick is high. A full sample-plus-convert cycle lasts (SAMPLE_TAD+12) periods, so while running, conv_busy rises once per cycle at a fixed spacing.
- R3: done goes to 0 on the edge where conv_busy rises. It goes to 1 on the edge where conv_busy falls. It stays 1 during the sample phase that follows. conv_busy high implies done low.
- R4: A write to address 0 with bit 0 equal to 0 clears done. Writing 1 to that bit has no effect. When a hardware set and a software clear land on the same edge, done ends at 1.
- R5: Let K be bits [11:8] of address 0. When bit 4 of address 0 is 1, irq is a one-cycle pulse that coincides with the done rise of every (K+1)-th conversion. When that bit is 0, irq stays 0.
- R6: When bit 3 of address 0 is 0, results fill entries 0, 1, 2 and onward in order. After every (K+1)-th result the write position returns to entry 0. The entry does not depend on the channel.
- R7: When bit 3 of address 0 is 1, every result overwrites entry 0, and a read at any address returns entry 0.
- R8: When bit 2 of address 0 is 1 and the mask at address 2 is non-zero, only the enabled channels are converted, in ascending order. After the highest enabled channel the scan returns to the lowest one, and it also returns to the lowest at every (K+1)-th conversion.
- R9: When scanning is off or the mask is zero, every conversion uses the channel in bits [3:0] of address 3.
- R10: Bit 1 of address 0 runs the block. Setting it from idle restarts the block count, the write position and the scan. Clearing it during a sample phase stops the block at once. Clearing it during a conversion lets that conversion finish first.
- R11: buf_rdata shows the entry selected by buf_raddr one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| rc_tick | input | 1 | Strobe from the slow internal clock source |
| conv_data | input | RES_W (10) | Result value from the analog converter |
| conv_busy | output | 1 | High during the conversion phase |
| conv_ch | output | 4 | Channel being sampled or converted |
| done | output | 1 | Conversion-complete flag |
| irq | output | 1 | One-cycle block-complete interrupt |
| buf_raddr | input | 4 | Result memory read address |
| buf_rdata | output | RES_W (10) | Result memory read data |

## Verification
The end of a conversion, where hardware sets done, can land on the same edge as a software write that clears done. The bench times a register write to the exact last cycle of a conversion: it counts 12·(M+1) cycles from the observed rise of conv_busy. It then expects done to read 1. A second clear, issued later in the sample phase, must read back 0. The interrupt pulse, the scan restart and the buffer wrap also coincide on one edge. A reference model in the bench predicts the channel, the interrupt and the memory entry for every completed conversion.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int NCH      = 16;
  localparam int CH_W     = $clog2(NCH);
  localparam int SMPI_W   = 4;
  localparam int DEPTH    = 1 << SMPI_W;
  localparam int PTR_W    = SMPI_W;
  localparam int MULT_W   = 6;
  localparam int CONV_TAD = 12;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic              run;
    logic              scan;
    logic              single;
    logic              irq_en;
    logic [SMPI_W-1:0] smpi;
    logic [MULT_W-1:0] mult;
    logic              src_rc;
    logic [NCH-1:0]    mask;
    logic [CH_W-1:0]   fixed_ch;
  } seq_cfg_t;

  // lowest enabled channel, 0 when nothing is enabled
  function automatic logic [CH_W-1:0] first_ch(input logic [NCH-1:0] mask);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) r = CH_W'(i);
    end
    return r;
  endfunction

  // lowest enabled channel above cur, wrapping to the lowest overall
  function automatic logic [CH_W-1:0] next_ch(input logic [NCH-1:0] mask,
                                              input logic [CH_W-1:0] cur);
    logic [CH_W-1:0] r;
    r = first_ch(mask);
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i] && (i > int'(cur))) r = CH_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output seq_cfg_t          cfg,
  output logic              sw_done_clr
);

  localparam int A_CTRL   = 0;
  localparam int A_CLK    = 1;
  localparam int A_SCAN   = 2;
  localparam int A_CH     = 3;
  localparam int B_DONE   = 0;
  localparam int B_RUN    = 1;
  localparam int B_SCAN   = 2;
  localparam int B_SINGLE = 3;
  localparam int B_IEN    = 4;
  localparam int B_SMPI   = 8;
  localparam int B_SRC    = REG_W - 1;

  logic sel_ctrl, sel_clk, sel_scan, sel_ch;

  assign sel_ctrl = we && (addr == ADDR_W'(A_CTRL));
  assign sel_clk  = we && (addr == ADDR_W'(A_CLK));
  assign sel_scan = we && (addr == ADDR_W'(A_SCAN));
  assign sel_ch   = we && (addr == ADDR_W'(A_CH));

  // zero written to the done position acts as a clear in the same edge
  assign sw_done_clr = sel_ctrl && !wdata[B_DONE];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (sel_ctrl) begin
        cfg.run    <= wdata[B_RUN];
        cfg.scan   <= wdata[B_SCAN];
        cfg.single <= wdata[B_SINGLE];
        cfg.irq_en <= wdata[B_IEN];
        cfg.smpi   <= wdata[B_SMPI +: SMPI_W];
      end
      if (sel_clk) begin
        cfg.mult   <= wdata[MULT_W-1:0];
        cfg.src_rc <= wdata[B_SRC];
      end
      if (sel_scan) cfg.mask <= wdata[NCH-1:0];
      if (sel_ch)   cfg.fixed_ch <= wdata[CH_W-1:0];
    end
  end

endmodule

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv #(
  parameter int MULT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              src_rc,
  input  logic              rc_tick,
  input  logic [MULT_W-1:0] mult,
  output logic              tick
);

  logic [MULT_W-1:0] cnt;
  logic              src_en;

  assign src_en = src_rc ? rc_tick : 1'b1;
  assign tick   = !clr && src_en && (cnt == mult);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (src_en) begin
      cnt <= (cnt == mult) ? '0 : cnt + 1'b1;
    end
  end

  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (tick && mult != '0) |=> !tick); // R2

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int SAMPLE_TAD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              scan,
  input  logic              irq_en,
  input  logic [SMPI_W-1:0] smpi,
  input  logic [NCH-1:0]    mask,
  input  logic [CH_W-1:0]   fixed_ch,
  input  logic              tick,
  input  logic              sw_done_clr,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic [CH_W-1:0]   ch,
  output logic              div_clr,
  output logic              restart,
  output logic              wr_en,
  output logic              wr_wrap
);

  localparam int TMAX = (SAMPLE_TAD > CONV_TAD) ? SAMPLE_TAD : CONV_TAD;
  localparam int TC_W = $clog2(TMAX + 1);

  seq_state_t        state;
  logic [TC_W-1:0]   tcnt;
  logic [SMPI_W-1:0] blk_cnt;
  logic [CH_W-1:0]   ch_q;
  logic              done_q;
  logic              irq_q;

  logic            use_scan;
  logic            samp_end;
  logic            conv_end;
  logic            wrap;
  logic [CH_W-1:0] start_ch;
  logic [CH_W-1:0] after_ch;

  always_comb begin
    use_scan = scan && (|mask);
    start_ch = use_scan ? first_ch(mask) : fixed_ch;
    wrap     = (blk_cnt == smpi);
    samp_end = (state == ST_SAMPLE) && run && tick && (tcnt == TC_W'(SAMPLE_TAD - 1));
    conv_end = (state == ST_CONV) && tick && (tcnt == TC_W'(CONV_TAD - 1));
    if (!use_scan)  after_ch = fixed_ch;
    else if (wrap)  after_ch = first_ch(mask);
    else            after_ch = next_ch(mask, ch_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tcnt    <= '0;
      blk_cnt <= '0;
      ch_q    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          tcnt <= '0;
          if (run) begin
            state   <= ST_SAMPLE;
            blk_cnt <= '0;
            ch_q    <= start_ch;
          end
        end
        ST_SAMPLE: begin
          if (!run) begin
            state <= ST_IDLE;
            tcnt  <= '0;
          end else if (tick) begin
            if (samp_end) begin
              state <= ST_CONV;
              tcnt  <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (tick) begin
            if (conv_end) begin
              tcnt    <= '0;
              state   <= run ? ST_SAMPLE : ST_IDLE;
              blk_cnt <= wrap ? '0 : blk_cnt + 1'b1;
              ch_q    <= after_ch;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // hardware set outranks every clear
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (conv_end)         done_q <= 1'b1;
      else if (samp_end)    done_q <= 1'b0;
      else if (sw_done_clr) done_q <= 1'b0;
      irq_q <= conv_end && wrap && irq_en;
    end
  end

  assign busy    = (state == ST_CONV);
  assign done    = done_q;
  assign irq     = irq_q;
  assign ch      = ch_q;
  assign div_clr = (state == ST_IDLE);
  assign restart = (state == ST_IDLE) && run;
  assign wr_en   = conv_end;
  assign wr_wrap = wrap;

  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done_q); // R3
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_q); // R3
  AST_DONE_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(done_q) |-> ($rose(busy) || $past(sw_done_clr))); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q); // R5

endmodule

// File: rtl/adcseq_resbuf.sv
module adcseq_resbuf
  import adcseq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             single,
  input  logic             restart,
  input  logic             wr_en,
  input  logic             wr_wrap,
  input  logic [RES_W-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [RES_W-1:0] rdata,
  output logic [PTR_W-1:0] wr_ptr
);

  logic [RES_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] waddr;
  logic [PTR_W-1:0] raddr_eff;

  assign waddr     = single ? '0 : wr_ptr;
  assign raddr_eff = single ? '0 : raddr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr_eff];
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      wr_ptr <= '0;
    end else if (wr_en) begin
      wr_ptr <= (single || wr_wrap) ? '0 : wr_ptr + 1'b1;
    end
  end

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !single && !wr_wrap && !restart) |=> (wr_ptr == $past(wr_ptr) + 1'b1)); // R6

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int SAMPLE_TAD = 4,
  parameter int REG_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             rc_tick,
  input  logic [RES_W-1:0] conv_data,
  output logic             conv_busy,
  output logic [CH_W-1:0]  conv_ch,
  output logic             done,
  output logic             irq,
  input  logic [PTR_W-1:0] buf_raddr,
  output logic [RES_W-1:0] buf_rdata
);

  seq_cfg_t         cfg;
  logic             sw_done_clr;
  logic             tick;
  logic             div_clr;
  logic             restart;
  logic             wr_en;
  logic             wr_wrap;
  logic [PTR_W-1:0] wr_ptr;

  adcseq_regs #(.REG_W(REG_W), .ADDR_W(2)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .we          (cfg_we),
    .addr        (cfg_addr),
    .wdata       (cfg_wdata),
    .cfg         (cfg),
    .sw_done_clr (sw_done_clr)
  );

  adcseq_clkdiv #(.MULT_W(MULT_W)) u_clkdiv (
    .clk     (clk),
    .rst     (rst),
    .clr     (div_clr),
    .src_rc  (cfg.src_rc),
    .rc_tick (rc_tick),
    .mult    (cfg.mult),
    .tick    (tick)
  );

  adcseq_ctrl #(.SAMPLE_TAD(SAMPLE_TAD)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .run         (cfg.run),
    .scan        (cfg.scan),
    .irq_en      (cfg.irq_en),
    .smpi        (cfg.smpi),
    .mask        (cfg.mask),
    .fixed_ch    (cfg.fixed_ch),
    .tick        (tick),
    .sw_done_clr (sw_done_clr),
    .busy        (conv_busy),
    .done        (done),
    .irq         (irq),
    .ch          (conv_ch),
    .div_clr     (div_clr),
    .restart     (restart),
    .wr_en       (wr_en),
    .wr_wrap     (wr_wrap)
  );

  adcseq_resbuf #(.RES_W(RES_W)) u_resbuf (
    .clk     (clk),
    .rst     (rst),
    .single  (cfg.single),
    .restart (restart),
    .wr_en   (wr_en),
    .wr_wrap (wr_wrap),
    .wdata   (conv_data),
    .raddr   (buf_raddr),
    .rdata   (buf_rdata),
    .wr_ptr  (wr_ptr)
  );

  AST_IRQ_PTR_HOME: assert property (@(posedge clk) disable iff (rst)
    irq |-> (wr_ptr == '0)); // R6

endmodule

// File: tb/adcseq_top_test.sv
module adcseq_top_test;

  localparam int RES_W = 10;
  localparam int SAMP  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = '0;
  logic [15:0]      cfg_wdata = '0;
  logic             rc_tick = 1'b0;
  logic [RES_W-1:0] conv_data;
  logic             conv_busy;
  logic [3:0]       conv_ch;
  logic             done;
  logic             irq;
  logic [3:0]       buf_raddr = '0;
  logic [RES_W-1:0] buf_rdata;

  always #5 clk = ~clk;

  adcseq_top #(.RES_W(RES_W), .SAMPLE_TAD(SAMP)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rc_tick(rc_tick), .conv_data(conv_data), .conv_busy(conv_busy), .conv_ch(conv_ch),
    .done(done), .irq(irq), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata)
  );

  int errs = 0, checks = 0;
  longint cyc = 0;
  int salt = 0;
  int rc_cnt = 0;

  // configuration mirror and reference model
  int c_mask = 0, c_fixed = 0, c_smpi = 0;
  bit c_scan = 0, c_single = 0, c_irq_en = 0;
  int m_ptr = 0, m_cnt = 0, m_ch = 0;
  int m_mem [16];
  bit m_val [16];
  int completions = 0;
  int exp_period = 0;
  bit have_start = 0;
  longint last_start = 0;
  bit p_busy = 0;
  int p_ch = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    rc_tick <= (rc_cnt == 2);
    rc_cnt  <= (rc_cnt == 2) ? 0 : rc_cnt + 1;
  end

  assign conv_data = RES_W'((int'(conv_ch) * 41 + salt) % 1024);

  function automatic int dval(int ch);
    return (ch * 41 + salt) % 1024;
  endfunction

  function automatic int b_first(int mask);
    for (int i = 0; i < 16; i++) if (mask[i]) return i;
    return 0;
  endfunction

  function automatic int b_next(int mask, int cur);
    for (int i = cur + 1; i < 16; i++) if (mask[i]) return i;
    return b_first(mask);
  endfunction

  function automatic int ctrl_word(bit run, bit done_b);
    return (c_smpi << 8) | (int'(c_irq_en) << 4) | (int'(c_single) << 3) |
           (int'(c_scan) << 2) | (int'(run) << 1) | int'(done_b);
  endfunction

  task automatic chk_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-conversion reference checks
  always @(negedge clk) begin
    if (!rst) begin
      if (conv_busy && !p_busy) begin
        chk_eq("R3 done low at conversion start", int'(done), 0);
        if (have_start) chk_eq("R2 conversion spacing", int'(cyc - last_start), exp_period);
        have_start = 1;
        last_start = cyc;
      end
      if (!conv_busy && p_busy) begin
        automatic bit wrap = (m_cnt == c_smpi);
        automatic int wa = c_single ? 0 : m_ptr;
        chk_eq("R3 done high at conversion end", int'(done), 1);
        if (c_scan && c_mask != 0) chk_eq("R8 scan channel", p_ch, m_ch);
        else                       chk_eq("R9 fixed channel", p_ch, m_ch);
        chk_eq("R5 irq at block end", int'(irq), int'(wrap && c_irq_en));
        m_mem[wa] = dval(p_ch);
        m_val[wa] = 1;
        m_ptr = (c_single || wrap) ? 0 : m_ptr + 1;
        if (!(c_scan && c_mask != 0)) m_ch = c_fixed;
        else if (wrap)                m_ch = b_first(c_mask);
        else                          m_ch = b_next(c_mask, m_ch);
        m_cnt = wrap ? 0 : m_cnt + 1;
        completions++;
      end
    end
    p_busy = conv_busy;
    p_ch   = int'(conv_ch);
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 2'(a);
    cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic start_run(int mult, bit src, int mask, int fixed, bit scan,
                           bit single, bit ien, int smpi, int slt);
    c_mask = mask; c_fixed = fixed; c_scan = scan; c_single = single;
    c_irq_en = ien; c_smpi = smpi; salt = slt;
    m_ptr = 0; m_cnt = 0;
    m_ch = (scan && mask != 0) ? b_first(mask) : fixed;
    have_start = 0; completions = 0;
    exp_period = (SAMP + 12) * (mult + 1) * (src ? 3 : 1);
    wr(1, (int'(src) << 15) | mult);
    wr(2, mask);
    wr(3, fixed);
    wr(0, ctrl_word(1, 1));
  endtask

  task automatic stop_run(int n);
    while (completions < n) @(posedge clk);
    wr(0, ctrl_word(0, 1));
    repeat (40) @(negedge clk);
    chk_eq("R10 idle after stop in sample phase", int'(conv_busy), 0);
    chk_eq("R10 no conversion after stop", completions, n);
  endtask

  task automatic check_buf();
    for (int i = 0; i < 16; i++) begin
      automatic int e = c_single ? 0 : i;
      if (m_val[e]) begin
        @(negedge clk);
        buf_raddr = 4'(i);
        @(negedge clk);
        chk_eq(c_single ? "R7 single entry read" : "R6 buffer entry",
               int'(buf_rdata), m_mem[e]);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_val[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1 reset busy", int'(conv_busy), 0);
    chk_eq("R1 reset done", int'(done), 0);
    chk_eq("R1 reset irq", int'(irq), 0);
    chk_eq("R1 reset channel", int'(conv_ch), 0);

    // fixed channel, fastest clock, block longer than the run: no irq
    start_run(0, 0, 0, 9, 0, 0, 1, 15, 3);
    stop_run(3);
    check_buf();

    // scan over channels 2,5,13,15 with a block of 6, slow source
    start_run(1, 1, 16'hA024, 0, 1, 0, 1, 5, 77);
    stop_run(14);
    check_buf();
    @(negedge clk); buf_raddr = 4'd0;
    @(negedge clk); buf_raddr = 4'd1;
    chk_eq("R11 read latency first", int'(buf_rdata), m_mem[0]);
    @(negedge clk);
    chk_eq("R11 read latency second", int'(buf_rdata), m_mem[1]);

    // single-entry mode
    start_run(2, 0, 16'h00F0, 0, 1, 1, 1, 2, 500);
    stop_run(5);
    check_buf();

    // irq disabled with short blocks
    start_run(0, 0, 0, 4, 1, 0, 0, 1, 13);
    stop_run(4);
    check_buf();

    // hardware set and software clear on the same edge
    start_run(1, 0, 0, 2, 0, 0, 1, 0, 200);
    @(negedge clk);
    while (!conv_busy) @(negedge clk);
    repeat (22) @(negedge clk);
    wr(0, ctrl_word(1, 0));
    chk_eq("R4 hardware set wins over same-edge clear", int'(done), 1);
    repeat (2) @(negedge clk);
    chk_eq("R3 done held in sample phase", int'(done), 1);
    wr(0, ctrl_word(1, 0));
    chk_eq("R4 software clear", int'(done), 0);
    wr(0, ctrl_word(1, 1));
    chk_eq("R4 writing one has no effect", int'(done), 0);
    stop_run(2);

    // stop requested during a conversion
    start_run(0, 0, 0, 7, 0, 0, 1, 0, 321);
    @(negedge clk);
    while (!conv_busy) @(negedge clk);
    wr(0, ctrl_word(0, 1));
    repeat (60) @(negedge clk);
    chk_eq("R10 conversion in flight completes", completions, 1);
    chk_eq("R10 idle after in-flight stop", int'(conv_busy), 0);
    check_buf();

    // constrained random runs
    for (int k = 0; k < 8; k++) begin
      automatic int mult = int'($urandom_range(0, 3));
      automatic bit src = 1'($urandom_range(0, 1));
      automatic int mask = int'($urandom_range(0, 65535) & $urandom_range(0, 65535));
      automatic bit scan = 1'($urandom_range(0, 1));
      automatic bit single = ($urandom_range(0, 3) == 0);
      automatic bit ien = 1'($urandom_range(0, 1));
      automatic int smpi = int'($urandom_range(0, 15));
      automatic int n = int'($urandom_range(1, 24));
      automatic int fixed = int'($urandom_range(0, 15));
      start_run(mult, src, mask, fixed, scan, single, ien, smpi, int'($urandom_range(0, 1023)));
      stop_run(n);
      check_buf();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule